// File: doc/BRIEF.md
# Two-Level Page Table Walker with Directory Entry Cache

This block turns a 32-bit linear address into a 32-bit physical address for 4 KB pages. It does this by reading two 32-bit entries from tables held in memory. The top ten address bits select an entry in the page directory. That entry names the 4 KB-aligned base of a second-level table. The next ten bits select an entry in that table, and this entry gives the frame base. The low twelve bits pass through unchanged as the byte offset. Each table is one 4 KB page of 1024 entries.

A translation is requested through a valid/ready port, and its result comes back as a one-cycle response pulse. Table entries are fetched through a read port that allows only one read outstanding at a time. A separate write strobe loads the directory base register. A small fully associative cache keeps recent directory entries, tagged by the directory index. On a hit the walker skips the first memory read.

Bit 0 of every entry is the present flag. If an entry is not present, the walk ends with a fault response. That response carries the linear address and the level that faulted. The walker then returns to idle.

Top module: `pt_walker`

## Requirements
- R1: A completed translation returns physical address = {table entry bits [31:12], linear address bits [11:0]}, with fault low.
- R2: The fetch address of an entry is {table base bits [31:12], 10-bit index, 2'b00}. The directory is indexed by linear bits [31:22] from the directory base register, and the table by linear bits [21:12] from the base held in the directory entry. Bits [11:0] written to the base register have no effect.
- R3: When a directory entry has bit 0 clear, the response has fault high and level 0. No table read follows.
- R4: When a table entry has bit 0 clear, the response has fault high and level 1.
- R5: Every response, fault or not, echoes the requested linear address. The walker is ready for a new request in the cycle after the response.
- R6: When the directory index hits in the directory entry cache, the walk performs exactly one memory read, and that read is the table entry.
- R7: A directory entry with bit 0 clear is never cached, so a repeated request to it reads the directory again.
- R8: A write to the directory base register invalidates every cache slot, so the next request misses and reads the directory.
- R9: When the cache is full, a miss that loads a new entry replaces the least recently used slot. Both hits and fills count as uses.
- R10: The block handles one request at a time. The ready signal is low from acceptance until the response. The response lasts one cycle. The memory request lasts one cycle, and no new read is issued until the previous one has returned.
- R11: After reset the walker is ready, has no response and no memory request pending, and its cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_vaddr | input | 32 | Linear address to translate |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_vaddr | output | 32 | Linear address of the response |
| rsp_paddr | output | 32 | Physical address (valid when no fault) |
| rsp_fault | output | 1 | Entry not present |
| rsp_fault_lvl | output | 1 | Faulting level: 0 directory, 1 table |
| mem_req_valid | output | 1 | One-cycle entry read request |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry value |
| base_we | input | 1 | Directory base register write strobe |
| base_wdata | input | 32 | New directory base (bits [11:0] ignored) |

## Verification
On every cycle the assertions check the following. The response and the memory request are single-cycle pulses. Ready drops after an accept and returns after a response. A completed translation keeps the page offset. No two valid cache slots share a tag. A base write leaves the cache empty.

Some behaviours only the directed scenarios can show, because they depend on a memory model with known table contents. These are the exact physical addresses, the entry fetch addresses, and the number of reads per walk. That read count is what reveals hits, the refusal to cache absent directory entries, flushes and least-recently-used replacement.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int ADDR_W    = 32;
    localparam int OFF_W     = 12;
    localparam int IDX_W     = 10;
    localparam int FRAME_W   = ADDR_W - OFF_W;
    localparam int ENT_LSB_W = OFF_W - IDX_W;
    localparam int PRESENT_B = 0;

    typedef enum logic [2:0] {
        WK_IDLE,
        WK_DIR_REQ,
        WK_DIR_WAIT,
        WK_TBL_REQ,
        WK_TBL_WAIT,
        WK_RESP
    } walk_st_e;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int BASE_W = 20,
    parameter int IX_W   = 10,
    parameter int OUT_W  = 32
) (
    input  logic [BASE_W-1:0] base,
    input  logic [IX_W-1:0]   index,
    output logic [OUT_W-1:0]  addr
);
    localparam int PAD_W = OUT_W - BASE_W - IX_W;

    assign addr = {base, index, {PAD_W{1'b0}}};
endmodule

// File: rtl/ptw_dir_cache.sv
module ptw_dir_cache #(
    parameter int ENTRIES = 2,
    parameter int TAG_W   = 10,
    parameter int DATA_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              lk_en,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data
);
    localparam int SEL_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][TAG_W-1:0]  tag;
        logic [ENTRIES-1:0][DATA_W-1:0] data;
        logic [ENTRIES-1:0][SEL_W-1:0]  age;
    } dc_state_t;

    dc_state_t          st_q, st_d;
    logic [ENTRIES-1:0] match;
    logic [SEL_W-1:0]   hit_sel, vict_sel, touch_sel;
    logic               found_free;
    logic               touch;

    always_comb begin
        lk_hit     = 1'b0;
        hit_sel    = '0;
        lk_data    = '0;
        found_free = 1'b0;
        vict_sel   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            match[i] = st_q.valid[i] && (st_q.tag[i] == lk_tag);
            if (match[i] && !lk_hit) begin
                lk_hit  = 1'b1;
                hit_sel = SEL_W'(i);
                lk_data = st_q.data[i];
            end
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (!st_q.valid[i] && !found_free) begin
                found_free = 1'b1;
                vict_sel   = SEL_W'(i);
            end
        end
        if (!found_free) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (st_q.age[i] > st_q.age[vict_sel]) vict_sel = SEL_W'(i);
            end
        end
    end

    always_comb begin
        st_d      = st_q;
        touch     = 1'b0;
        touch_sel = '0;
        if (flush) begin
            st_d.valid = '0;
        end else if (fill_en) begin
            st_d.valid[vict_sel] = 1'b1;
            st_d.tag[vict_sel]   = fill_tag;
            st_d.data[vict_sel]  = fill_data;
            touch     = 1'b1;
            touch_sel = vict_sel;
        end else if (lk_en && lk_hit) begin
            touch     = 1'b1;
            touch_sel = hit_sel;
        end
        if (touch) begin
            for (int j = 0; j < ENTRIES; j++) begin
                if (SEL_W'(j) == touch_sel)
                    st_d.age[j] = '0;
                else if (st_q.age[j] < st_q.age[touch_sel])
                    st_d.age[j] = st_q.age[j] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.valid <= '0;
            st_q.tag   <= '0;
            st_q.data  <= '0;
            for (int k = 0; k < ENTRIES; k++) st_q.age[k] <= SEL_W'(k);
        end else begin
            st_q <= st_d;
        end
    end

    // R9
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(match) <= 1);

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.valid == '0));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int DC_ENTRIES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    output logic        rsp_valid,
    output logic [31:0] rsp_vaddr,
    output logic [31:0] rsp_paddr,
    output logic        rsp_fault,
    output logic        rsp_fault_lvl,
    output logic        mem_req_valid,
    output logic [31:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    input  logic        base_we,
    input  logic [31:0] base_wdata
);
    localparam int DIR_HI = ADDR_W - 1;
    localparam int DIR_LO = ADDR_W - IDX_W;
    localparam int TBL_HI = DIR_LO - 1;
    localparam int TBL_LO = OFF_W;

    typedef struct packed {
        walk_st_e           st;
        logic [ADDR_W-1:0]  vaddr;
        logic [FRAME_W-1:0] dir_base;
        logic [FRAME_W-1:0] tbl_base;
        logic               stale;
        logic [ADDR_W-1:0]  paddr;
        logic               fault;
        logic               lvl;
    } walk_t;

    walk_t              w_q, w_d;
    logic               lk_en, lk_hit, fill_en;
    logic [FRAME_W-1:0] lk_data, sel_base;
    logic [IDX_W-1:0]   sel_idx;
    logic [ADDR_W-1:0]  ent_addr;

    ptw_dir_cache #(
        .ENTRIES (DC_ENTRIES),
        .TAG_W   (IDX_W),
        .DATA_W  (FRAME_W)
    ) i_dcache (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (base_we),
        .lk_en     (lk_en),
        .lk_tag    (req_vaddr[DIR_HI:DIR_LO]),
        .lk_hit    (lk_hit),
        .lk_data   (lk_data),
        .fill_en   (fill_en),
        .fill_tag  (w_q.vaddr[DIR_HI:DIR_LO]),
        .fill_data (mem_rsp_data[ADDR_W-1:OFF_W])
    );

    assign sel_base = (w_q.st == WK_DIR_REQ) ? w_q.dir_base : w_q.tbl_base;
    assign sel_idx  = (w_q.st == WK_DIR_REQ) ? w_q.vaddr[DIR_HI:DIR_LO]
                                             : w_q.vaddr[TBL_HI:TBL_LO];

    ptw_entry_addr #(
        .BASE_W (FRAME_W),
        .IX_W   (IDX_W),
        .OUT_W  (ADDR_W)
    ) i_eaddr (
        .base  (sel_base),
        .index (sel_idx),
        .addr  (ent_addr)
    );

    always_comb begin
        w_d           = w_q;
        req_ready     = 1'b0;
        rsp_valid     = 1'b0;
        mem_req_valid = 1'b0;
        lk_en         = 1'b0;
        fill_en       = 1'b0;
        case (w_q.st)
            WK_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    lk_en     = 1'b1;
                    w_d.vaddr = req_vaddr;
                    w_d.stale = 1'b0;
                    if (lk_hit) begin
                        w_d.tbl_base = lk_data;
                        w_d.st       = WK_TBL_REQ;
                    end else begin
                        w_d.st       = WK_DIR_REQ;
                    end
                end
            end
            WK_DIR_REQ: begin
                mem_req_valid = 1'b1;
                w_d.st        = WK_DIR_WAIT;
            end
            WK_DIR_WAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_data[PRESENT_B]) begin
                        fill_en      = !w_q.stale && !base_we;
                        w_d.tbl_base = mem_rsp_data[ADDR_W-1:OFF_W];
                        w_d.st       = WK_TBL_REQ;
                    end else begin
                        w_d.fault = 1'b1;
                        w_d.lvl   = 1'b0;
                        w_d.paddr = '0;
                        w_d.st    = WK_RESP;
                    end
                end
            end
            WK_TBL_REQ: begin
                mem_req_valid = 1'b1;
                w_d.st        = WK_TBL_WAIT;
            end
            WK_TBL_WAIT: begin
                if (mem_rsp_valid) begin
                    w_d.lvl = 1'b1;
                    if (mem_rsp_data[PRESENT_B]) begin
                        w_d.fault = 1'b0;
                        w_d.paddr = {mem_rsp_data[ADDR_W-1:OFF_W], w_q.vaddr[OFF_W-1:0]};
                    end else begin
                        w_d.fault = 1'b1;
                        w_d.paddr = '0;
                    end
                    w_d.st = WK_RESP;
                end
            end
            WK_RESP: begin
                rsp_valid = 1'b1;
                w_d.st    = WK_IDLE;
            end
            default: w_d.st = WK_IDLE;
        endcase
        if (base_we) begin
            w_d.dir_base = base_wdata[ADDR_W-1:OFF_W];
            w_d.stale    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '{st: WK_IDLE, default: '0};
        end else begin
            w_q <= w_d;
        end
    end

    assign mem_req_addr  = ent_addr;
    assign rsp_vaddr     = w_q.vaddr;
    assign rsp_paddr     = w_q.paddr;
    assign rsp_fault     = w_q.fault;
    assign rsp_fault_lvl = w_q.lvl;

    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    mem_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R5
    idle_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

    // R1
    offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == rsp_vaddr[OFF_W-1:0]));
endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_vaddr, rsp_paddr;
    logic        rsp_fault, rsp_fault_lvl;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] mem [logic [31:0]];
    int          rd_cnt = 0;
    logic [31:0] rd_log [0:255];
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;

    // per-walk results
    logic [31:0] r_pa, r_va;
    logic        r_ft, r_lv, r_ok, r_rdy;
    int          r_reads, r_first;

    always #10 clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_vaddr(rsp_vaddr), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .base_we(base_we), .base_wdata(base_wdata)
    );

    always @(posedge clk) begin
        if (pend) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem.exists(pend_addr) ? mem[pend_addr] : 32'h0;
            pend          <= 1'b0;
        end else begin
            mem_rsp_valid <= 1'b0;
        end
        if (mem_req_valid) begin
            pend      <= 1'b1;
            pend_addr <= mem_req_addr;
            rd_log[rd_cnt % 256] <= mem_req_addr;
            rd_cnt    <= rd_cnt + 1;
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic write_base(logic [31:0] v);
        @(negedge clk);
        base_we = 1'b1; base_wdata = v;
        @(negedge clk);
        base_we = 1'b0;
    endtask

    task automatic walk(logic [31:0] va);
        int start;
        @(negedge clk);
        start = rd_cnt;
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        r_rdy = req_ready;
        r_ok = 1'b0;
        for (int t = 0; t < 60 && !r_ok; t++) begin
            if (rsp_valid) begin
                r_ok = 1'b1; r_pa = rsp_paddr; r_va = rsp_vaddr;
                r_ft = rsp_fault; r_lv = rsp_fault_lvl;
            end else begin
                @(negedge clk);
            end
        end
        @(negedge clk);
        r_reads = rd_cnt - start;
        r_first = start;
    endtask

    task automatic t_reset;
        chk("R11", "req_ready", {31'b0, req_ready}, 32'd1);
        chk("R11", "rsp_valid", {31'b0, rsp_valid}, 32'd0);
        chk("R11", "mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
    endtask

    task automatic t_miss_walk;
        write_base(32'h0010_0000);
        walk(32'h0040_1ABC);
        chk("R1", "paddr", r_pa, 32'h1234_5ABC);
        chk("R1", "fault", {31'b0, r_ft}, 32'd0);
        chk("R5", "vaddr echo", r_va, 32'h0040_1ABC);
        chk("R10", "ready low while busy", {31'b0, r_rdy}, 32'd0);
        chk("R2", "reads", r_reads, 2);
        chk("R2", "dir addr", rd_log[r_first % 256], 32'h0010_0004);
        chk("R2", "tbl addr", rd_log[(r_first + 1) % 256], 32'h0020_0004);
        chk("R5", "ready after rsp", {31'b0, req_ready}, 32'd1);
    endtask

    task automatic t_hit_walk;
        walk(32'h0040_2123);
        chk("R6", "paddr", r_pa, 32'h0ABC_D123);
        chk("R6", "reads", r_reads, 1);
        chk("R6", "tbl addr", rd_log[r_first % 256], 32'h0020_0008);
    endtask

    task automatic t_dir_fault;
        for (int k = 0; k < 2; k++) begin
            walk(32'h0080_0456);
            chk("R3", "fault", {31'b0, r_ft}, 32'd1);
            chk("R3", "level", {31'b0, r_lv}, 32'd0);
            chk("R5", "vaddr", r_va, 32'h0080_0456);
            chk("R7", "reads (absent dir never cached)", r_reads, 1);
        end
    endtask

    task automatic t_tbl_fault;
        walk(32'h0040_3000);
        chk("R4", "fault", {31'b0, r_ft}, 32'd1);
        chk("R4", "level", {31'b0, r_lv}, 32'd1);
        chk("R4", "reads", r_reads, 1);
        chk("R5", "ready after fault", {31'b0, req_ready}, 32'd1);
    endtask

    task automatic t_lru;
        walk(32'h00C0_0010);
        chk("R9", "fill idx3 reads", r_reads, 2);
        chk("R9", "idx3 paddr", r_pa, 32'h6666_6010);
        walk(32'h0040_1ABC);
        chk("R9", "idx1 hit", r_reads, 1);
        walk(32'h0100_0000);
        chk("R9", "idx4 miss", r_reads, 2);
        chk("R9", "idx4 paddr", r_pa, 32'h7777_7000);
        walk(32'h0040_1ABC);
        chk("R9", "idx1 kept", r_reads, 1);
        walk(32'h00C0_0010);
        chk("R9", "idx3 evicted", r_reads, 2);
        walk(32'h0040_1ABC);
        chk("R9", "idx1 still kept", r_reads, 1);
    endtask

    task automatic t_flush;
        write_base(32'h0010_0000);
        walk(32'h0040_1ABC);
        chk("R8", "reads after base write", r_reads, 2);
        chk("R8", "paddr", r_pa, 32'h1234_5ABC);
    endtask

    task automatic t_new_base;
        write_base(32'h0060_0ABC);
        walk(32'h0040_0ABC);
        chk("R2", "reads", r_reads, 2);
        chk("R2", "dir addr ignores low base bits", rd_log[r_first % 256], 32'h0060_0004);
        chk("R2", "tbl addr", rd_log[(r_first + 1) % 256], 32'h0080_0000);
        chk("R1", "paddr", r_pa, 32'h0F0F_0ABC);
    endtask

    initial begin
        mem[32'h0010_0004] = 32'h0020_0001;
        mem[32'h0020_0004] = 32'h1234_5001;
        mem[32'h0020_0008] = 32'h0ABC_D003;
        mem[32'h0010_0008] = 32'h0030_0000;
        mem[32'h0020_000C] = 32'h5555_5000;
        mem[32'h0010_000C] = 32'h0040_0001;
        mem[32'h0040_0000] = 32'h6666_6001;
        mem[32'h0010_0010] = 32'h0050_0001;
        mem[32'h0050_0000] = 32'h7777_7001;
        mem[32'h0060_0004] = 32'h0080_0001;
        mem[32'h0080_0000] = 32'h0F0F_0001;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_miss_walk();
        t_hit_walk();
        t_dir_fault();
        t_tbl_fault();
        t_lru();
        t_flush();
        t_new_base();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule